// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block is the per-channel digital sequencer of a current-mode synchronous step-down converter. It decides, on every cycle of a fast system clock, whether the high-side switch, the low-side switch or neither is enabled. Its inputs are digital flags from the analog front end: an oscillator tick that marks the start of a switching period, the PWM trip, a light-load skip threshold, positive and negative current limits, an inductor zero-cross flag, a switch-node-at-zero flag and a feedback-below-reference flag.

Two operating modes are offered. In forced fixed-frequency mode every period starts with a high-side pulse and the low-side switch may carry reverse current. In pulse-skipping mode a period starts only when feedback is low, and the low-side switch releases at zero current. A mode request is honoured at the next oscillator tick. The turn-over from the high side to the low side waits for the switch node to reach zero, but never longer than a parameter number of clocks. Returning from the low side to the high side always inserts one clock with both switches off.

Top module: `buck_gate_seq`

## Requirements
- R1: While `rst` is high at a clock edge, or `ch_en` is low, both enables are low after that edge and no tick turns either switch on.
- R2: `hs_en` and `ls_en` are never high together; a tick that ends a low-side interval gives exactly one clock with both low before `hs_en` rises.
- R3: In forced mode (`skip_mode`=0 at the tick) a tick turns `hs_en` on at that edge, and a `pwm_trip` sampled during a high-side interval turns it off at that edge.
- R4: After the high side turns off, `ls_en` rises at the first edge where `sw_at_zero` is sampled high, or after `DT_MAX` clocks with both low, whichever comes first.
- R5: In forced mode `zero_cross` has no effect; the low side stays on until a tick or a negative current limit.
- R6: In pulse-skipping mode (`skip_mode`=1 at the tick) a `zero_cross` sampled during a low-side interval turns `ls_en` off at that edge.
- R7: In pulse-skipping mode `hs_en` turns on only at a tick with `fb_low` high, and turns off on `skip_trip`; `pwm_trip` does not end it.
- R8: `ilim_pos` sampled during a high-side interval turns `hs_en` off at that edge, and a tick sampled with `ilim_pos` high does not turn the high side on.
- R9: `ilim_neg` sampled during a low-side interval turns `ls_en` off at that edge in either mode.
- R10: `skip_mode` is taken into use only at a tick; between ticks a change of `skip_mode` has no effect.
- R11: When a high-side turn-off flag and a tick are sampled at the same edge, the high side turns off and the new period is not started at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_en | input | 1 | Channel enable; low forces both switches off |
| osc_tick | input | 1 | One-clock pulse marking the start of a switching period |
| skip_mode | input | 1 | Mode request: 1 pulse-skipping, 0 forced fixed-frequency |
| fb_low | input | 1 | Feedback below reference |
| pwm_trip | input | 1 | Sensed current reached the control level |
| skip_trip | input | 1 | Sensed current reached the light-load skip threshold |
| ilim_pos | input | 1 | Positive current limit exceeded |
| ilim_neg | input | 1 | Negative current limit exceeded |
| zero_cross | input | 1 | Inductor current has reached zero |
| sw_at_zero | input | 1 | Switch node has fallen to zero |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The tick that opens a new period can land in the same clock as a high-side turn-off flag, a negative current limit, or the last clocks of a dead-time interval. The bench drives each of these pairs in one cycle (tick with `pwm_trip`, tick with `ilim_pos`, tick with `ilim_neg` during the low side, tick during dead time) and judges the result purely at the two enables in the following clocks: the turn-off must win over the tick, and a low-side exit must still pass through one all-off clock. The dead-time cap is swept against every arrival clock of `sw_at_zero` so the expected rise is computed as the smaller of the arrival and the cap.

// File: rtl/gs_pkg.sv
package gs_pkg;

  typedef enum logic [2:0] {
    GS_IDLE    = 3'd0,
    GS_HS_ON   = 3'd1,
    GS_DEAD_HL = 3'd2,
    GS_LS_ON   = 3'd3,
    GS_DEAD_LH = 3'd4
  } gs_state_e;

  // High-side end condition: the trip that counts depends on the mode.
  function automatic logic gs_hs_end(input logic skip, input logic pwm,
                                     input logic skp, input logic lim);
    return lim | (skip ? skp : pwm);
  endfunction

  // Dead-time cap reached once the count of elapsed clocks is lim-1.
  function automatic logic gs_dt_cap(input int unsigned cnt,
                                     input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/gs_mode_latch.sv
module gs_mode_latch (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic req,
  output logic mode_q,
  output logic mode_now
);
  // The request is used from the tick on; between ticks the held copy rules.
  assign mode_now = tick ? req : mode_q;

  always_ff @(posedge clk) begin
    if (rst)       mode_q <= 1'b0;
    else if (tick) mode_q <= req;
  end

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> mode_q == $past(mode_q));

endmodule

// File: rtl/gs_deadtime.sv
module gs_deadtime #(
  parameter int unsigned DT_MAX = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  import gs_pkg::*;
  localparam int unsigned CW = $clog2(DT_MAX + 1);

  logic [CW-1:0] cnt;

  assign done = gs_dt_cap(32'(cnt), DT_MAX);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (!done)   cnt <= cnt + 1'b1;
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) < DT_MAX);

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
  parameter int unsigned DT_MAX = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic ch_en,
  input  logic osc_tick,
  input  logic skip_mode,
  input  logic fb_low,
  input  logic pwm_trip,
  input  logic skip_trip,
  input  logic ilim_pos,
  input  logic ilim_neg,
  input  logic zero_cross,
  input  logic sw_at_zero,
  output logic hs_en,
  output logic ls_en
);
  import gs_pkg::*;

  gs_state_e state, state_nx;
  logic mode_q, mode_now;
  logic dt_run, dt_done;
  logic start_evt, hs_end_evt, ls_end_evt, turn_evt;

  gs_mode_latch u_mode (
    .clk(clk), .rst(rst), .tick(osc_tick), .req(skip_mode),
    .mode_q(mode_q), .mode_now(mode_now)
  );

  assign dt_run = (state == GS_DEAD_HL);

  gs_deadtime #(.DT_MAX(DT_MAX)) u_dt (
    .clk(clk), .rst(rst), .run(dt_run), .done(dt_done)
  );

  // Named events for the next-state logic and the assertions.
  assign start_evt  = osc_tick && (!mode_now || fb_low) && !ilim_pos;
  assign hs_end_evt = gs_hs_end(mode_now, pwm_trip, skip_trip, ilim_pos);
  assign ls_end_evt = ilim_neg || (mode_now && zero_cross);
  assign turn_evt   = sw_at_zero || dt_done;

  always_comb begin
    state_nx = state;
    unique case (state)
      GS_IDLE:    if (start_evt) state_nx = GS_HS_ON;
      GS_HS_ON:   if (hs_end_evt) state_nx = GS_DEAD_HL;
      GS_DEAD_HL: begin
        if (start_evt)      state_nx = GS_HS_ON;
        else if (turn_evt)  state_nx = GS_LS_ON;
      end
      GS_LS_ON: begin
        if (start_evt)       state_nx = GS_DEAD_LH;
        else if (ls_end_evt) state_nx = GS_IDLE;
      end
      GS_DEAD_LH: state_nx = ilim_pos ? GS_IDLE : GS_HS_ON;
      default:    state_nx = GS_IDLE;
    endcase
    if (!ch_en) state_nx = GS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= GS_IDLE;
    else     state <= state_nx;
  end

  assign hs_en = (state == GS_HS_ON);
  assign ls_en = (state == GS_LS_ON);

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
    !(hs_en && ls_en));

  assert_ls_after_gap_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_en) |-> !$past(hs_en));

  assert_hs_after_gap_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en) |-> !$past(ls_en));

  assert_disable_off_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!ch_en) |-> (!hs_en && !ls_en));

  assert_pos_limit_R8: assert property (@(posedge clk) disable iff (rst)
    $past(hs_en && ilim_pos) |-> !hs_en);

  assert_neg_limit_R9: assert property (@(posedge clk) disable iff (rst)
    $past(ls_en && ilim_neg) |-> !ls_en);

  assert_skip_zc_R6: assert property (@(posedge clk) disable iff (rst)
    $past(ls_en && zero_cross && mode_q && !osc_tick) |-> !ls_en);

  assert_dt_cap_R4: assert property (@(posedge clk) disable iff (rst)
    $past(dt_run && dt_done && !osc_tick && ch_en) |-> ls_en);

  assert_trip_wins_R11: assert property (@(posedge clk) disable iff (rst)
    $past(hs_en && !mode_q && pwm_trip) |-> !hs_en);

endmodule

// File: tb/test_buck_gate_seq.sv
module test_buck_gate_seq;
  localparam int DT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1, ch_en = 1'b1, osc_tick = 1'b0, skip_mode = 1'b0;
  logic fb_low = 1'b0, pwm_trip = 1'b0, skip_trip = 1'b0;
  logic ilim_pos = 1'b0, ilim_neg = 1'b0, zero_cross = 1'b0, sw_at_zero = 1'b0;
  logic hs_en, ls_en;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  buck_gate_seq #(.DT_MAX(DT)) i_buck_gate_seq (
    .clk(clk), .rst(rst), .ch_en(ch_en), .osc_tick(osc_tick),
    .skip_mode(skip_mode), .fb_low(fb_low), .pwm_trip(pwm_trip),
    .skip_trip(skip_trip), .ilim_pos(ilim_pos), .ilim_neg(ilim_neg),
    .zero_cross(zero_cross), .sw_at_zero(sw_at_zero),
    .hs_en(hs_en), .ls_en(ls_en)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic eh, input logic el);
    checks++;
    if (hs_en !== eh || ls_en !== el) begin
      errors++;
      $display("FAIL %s: hs/ls=%b%b expected %b%b at %0t", req, hs_en, ls_en, eh, el, $time);
    end
  endtask

  // R2: overlap watched on every clock after reset
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (hs_en && ls_en) begin
        errors++;
        $display("FAIL R2: hs/ls=11 expected not both at %0t", $time);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    chk("R1", 0, 0);
    rst = 0; cyc();
    chk("R1", 0, 0);

    // R3 forced start and hold
    osc_tick = 1; cyc(); osc_tick = 0;
    chk("R3", 1, 0);
    repeat (3) begin cyc(); chk("R3", 1, 0); end

    // R4 dead-time sweep: sw_at_zero arrives at clock d, cap at DT
    for (int d = 1; d <= DT + 2; d++) begin
      int e;
      e = (d < DT) ? d : DT;
      pwm_trip = 1; cyc(); pwm_trip = 0;
      chk("R3", 0, 0);
      for (int k = 1; k <= DT + 1; k++) begin
        sw_at_zero = (k >= d); cyc();
        chk("R4", 0, (k >= e));
      end
      sw_at_zero = 0;
      osc_tick = 1; cyc(); osc_tick = 0;
      chk("R2", 0, 0);
      cyc(); chk("R2", 1, 0);
    end

    // R5 forced: zero_cross ignored
    pwm_trip = 1; cyc(); pwm_trip = 0;
    sw_at_zero = 1; cyc(); sw_at_zero = 0;
    chk("R4", 0, 1);
    zero_cross = 1;
    repeat (3) begin cyc(); chk("R5", 0, 1); end
    zero_cross = 0;

    // R9 negative limit
    ilim_neg = 1; cyc(); ilim_neg = 0;
    chk("R9", 0, 0);
    cyc(); chk("R9", 0, 0);

    // R8 positive limit blocks start and ends high side
    osc_tick = 1; ilim_pos = 1; cyc(); osc_tick = 0; ilim_pos = 0;
    chk("R8", 0, 0);
    osc_tick = 1; cyc(); osc_tick = 0;
    chk("R3", 1, 0);
    ilim_pos = 1; cyc(); ilim_pos = 0;
    chk("R8", 0, 0);
    sw_at_zero = 1; cyc(); sw_at_zero = 0;
    chk("R4", 0, 1);

    // R9 / R2 tick together with negative limit
    osc_tick = 1; ilim_neg = 1; cyc(); osc_tick = 0; ilim_neg = 0;
    chk("R9", 0, 0);
    cyc(); chk("R2", 1, 0);

    // R11 trip and tick in the same clock
    osc_tick = 1; pwm_trip = 1; cyc(); osc_tick = 0; pwm_trip = 0;
    chk("R11", 0, 0);
    cyc(); chk("R11", 0, 0);
    osc_tick = 1; cyc(); osc_tick = 0;
    chk("R3", 1, 0);

    // R10 mode request held until tick
    pwm_trip = 1; cyc(); pwm_trip = 0;
    sw_at_zero = 1; cyc(); sw_at_zero = 0;
    chk("R4", 0, 1);
    skip_mode = 1; zero_cross = 1; cyc();
    chk("R10", 0, 1);
    zero_cross = 0; osc_tick = 1; cyc(); osc_tick = 0;
    chk("R10", 0, 1);
    zero_cross = 1; cyc(); zero_cross = 0;
    chk("R6", 0, 0);

    // R7 pulse-skipping start and end
    fb_low = 1; cyc();
    chk("R7", 0, 0);
    osc_tick = 1; cyc(); osc_tick = 0; fb_low = 0;
    chk("R7", 1, 0);
    pwm_trip = 1; cyc(); pwm_trip = 0;
    chk("R7", 1, 0);
    skip_trip = 1; cyc(); skip_trip = 0;
    chk("R7", 0, 0);
    repeat (DT - 1) begin cyc(); chk("R4", 0, 0); end
    cyc(); chk("R4", 0, 1);
    osc_tick = 1; cyc(); osc_tick = 0;
    chk("R7", 0, 1);
    zero_cross = 1; cyc(); zero_cross = 0;
    chk("R6", 0, 0);
    osc_tick = 1; fb_low = 1; ilim_pos = 1; cyc();
    osc_tick = 0; fb_low = 0; ilim_pos = 0;
    chk("R8", 0, 0);

    // R10 back to forced at a tick, no fb_low needed
    skip_mode = 0; osc_tick = 1; cyc(); osc_tick = 0;
    chk("R10", 1, 0);

    // R1 disable and reset
    ch_en = 0; cyc();
    chk("R1", 0, 0);
    osc_tick = 1; cyc(); osc_tick = 0;
    chk("R1", 0, 0);
    ch_en = 1;
    osc_tick = 1; cyc(); osc_tick = 0;
    chk("R3", 1, 0);
    rst = 1; cyc();
    chk("R1", 0, 0);
    rst = 0; cyc();
    chk("R1", 0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule